// File: doc/BRIEF.md
# Associated-Data and Payload Address Sequencer

This block generates the wide-port addresses of two 128-bit RAMs that sit around an authenticated-cipher engine. One RAM supplies the engine's input and the other collects its output. When the engine asks for an input word, the sequencer advances the input address. It first walks the associated-data region, which starts at word 0x40. When the last associated-data word has been taken, it jumps to payload word 0x00 and carries on through the payload. Each word the engine produces is written into the output RAM at the current output address, and that address then advances by one.

A mode input picks the direction of the data flow. In forward mode, RAM1 is the source and RAM2 is the sink. In reverse mode, the two roles are swapped. A launch pulse does three things: it takes the associated-data length in bytes, rounds it up to whole 16-byte words, and places the input address at the start of the right region. A small register port can load either address directly, and such a load takes precedence over any update the sequencer would make in that cycle. The output address is not changed by a launch, so it must be set to zero through the register port before the operation starts.

Top module: `aadseq_top`

## Requirements
- R1: After an asynchronous active-low reset, both RAM addresses read 0, the remaining associated-data word count reads 0, and both write enables are low.
- R2: A launch with a non-zero byte count sets the input address to 0x40 on the next cycle and sets the remaining count to ceil(bytes/16), where bytes is the 16-bit byte count.
- R3: A launch with a byte count of 0 sets the input address to 0x00 on the next cycle and sets the remaining count to 0.
- R4: A read strobe, with no launch, while the remaining count is greater than 1, increments the input address by one and decrements the remaining count by one.
- R5: A read strobe, with no launch, while the remaining count equals 1, sets the input address to 0x00 and the remaining count to 0.
- R6: A read strobe, with no launch, while the remaining count is 0, increments the input address by one, modulo 128. The count stays at 0.
- R7: An output-valid strobe raises the output RAM's write enable in the same cycle. In that cycle the write data equals the engine's output word, and the write goes to the current output address. The output address then increments by one, modulo 128, so 127 becomes 0.
- R8: With mode 0, RAM1 is the input RAM and RAM2 is the output RAM. With mode 1, the roles are swapped. The write enable of the input RAM stays low in both modes.
- R9: A register write with select 0 loads the RAM1 address, and one with select 1 loads the RAM2 address. In both cases the loaded value appears on the next cycle and overrides any sequencer update to that address in the same cycle.
- R10: When a launch and a read strobe arrive in the same cycle, the launch is applied and the read strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| mode | input | 1 | 0: RAM1 is input and RAM2 is output; 1: the roles are swapped |
| start | input | 1 | Launch pulse |
| aadBytes | input | 16 | Associated-data length in bytes, sampled on launch |
| rdStrobe | input | 1 | Engine takes the current input word |
| outValid | input | 1 | Engine presents an output word |
| outWord | input | 128 | Engine output word |
| cfgWrEn | input | 1 | Register write of an address |
| cfgSel | input | 1 | 0: RAM1 address; 1: RAM2 address |
| cfgData | input | 7 | Address value to load |
| ram1Addr | output | 7 | RAM1 wide-port address |
| ram2Addr | output | 7 | RAM2 wide-port address |
| ram1WrEn | output | 1 | RAM1 wide-port write enable |
| ram2WrEn | output | 1 | RAM2 wide-port write enable |
| wrData | output | 128 | Write data for whichever RAM is written |
| aadLeft | output | 13 | Remaining associated-data words |

## Verification
The assertions check the single-cycle rules on every cycle:
- the countdown decrement;
- the load of 0x40 on a launch;
- a payload step of the RAM1 address;
- a step of the output address after a write;
- the precedence of a register load.

Only the bench scenarios can show the longer behaviour:
- the jump from the associated-data region to payload address 0 after a whole run of strobes;
- the rounding of odd byte counts;
- the wrap of the output address from 127 to 0;
- the swap of RAM roles when the mode changes.

// File: rtl/aadseq_pkg.sv
package aadseq_pkg;
  // Strobes from the control unit to the address datapath
  typedef struct packed {
    logic inLoadAad;   // input address to the associated-data base
    logic inLoadZero;  // input address to payload word 0
    logic inStep;      // input address plus one
    logic outStep;     // write output word, output address plus one
  } seqStrb_t;
endpackage

// File: rtl/aadseq_ctrl.sv
module aadseq_ctrl
  import aadseq_pkg::*;
#(
  parameter int BYTE_W     = 16,
  parameter int WORD_BYTES = 16,
  localparam int SH        = $clog2(WORD_BYTES),
  localparam int CNT_W     = BYTE_W - SH + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [BYTE_W-1:0] aadBytes,
  input  logic              rdStrobe,
  input  logic              outValid,
  output seqStrb_t          strb,
  output logic [CNT_W-1:0]  aadLeft
);
  logic [BYTE_W:0]  rounded;
  logic [CNT_W-1:0] wordCnt;
  logic             lastAad;

  always_comb begin
    rounded = {1'b0, aadBytes} + (BYTE_W+1)'(WORD_BYTES - 1);
    wordCnt = CNT_W'(rounded >> SH);
    lastAad = (aadLeft == CNT_W'(1));
    strb.inLoadAad  = start && (wordCnt != '0);
    strb.inLoadZero = (start && (wordCnt == '0)) || (!start && rdStrobe && lastAad);
    strb.inStep     = !start && rdStrobe && !lastAad;
    strb.outStep    = outValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           aadLeft <= '0;
    else if (start)                      aadLeft <= wordCnt;
    else if (rdStrobe && aadLeft != '0)  aadLeft <= aadLeft - CNT_W'(1);
  end

  a_r4_countdown: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && !start && aadLeft > CNT_W'(1)) |=> aadLeft == $past(aadLeft) - CNT_W'(1));
  a_r5_count_done: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && !start && aadLeft == CNT_W'(1)) |=> aadLeft == '0);
  a_r10_start_wins: assert property (@(posedge clk) disable iff (!rstN)
    (start && aadBytes == '0) |=> aadLeft == '0);
endmodule

// File: rtl/aadseq_dpath.sv
module aadseq_dpath
  import aadseq_pkg::*;
#(
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 128,
  parameter int AAD_BASE = 'h40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mode,
  input  seqStrb_t          strb,
  input  logic              cfgWrEn,
  input  logic              cfgSel,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic [DATA_W-1:0] outWord,
  output logic [ADDR_W-1:0] ram1Addr,
  output logic [ADDR_W-1:0] ram2Addr,
  output logic              ram1WrEn,
  output logic              ram2WrEn,
  output logic [DATA_W-1:0] wrData
);
  logic [ADDR_W-1:0] addr1, addr2, inCur, outCur, inNext, outNext, nxt1, nxt2;
  logic              cfgHit1, cfgHit2;

  always_comb begin
    inCur  = mode ? addr2 : addr1;
    outCur = mode ? addr1 : addr2;
    if (strb.inLoadAad)       inNext = ADDR_W'(AAD_BASE);
    else if (strb.inLoadZero) inNext = '0;
    else if (strb.inStep)     inNext = inCur + ADDR_W'(1);
    else                      inNext = inCur;
    outNext = strb.outStep ? outCur + ADDR_W'(1) : outCur;
    nxt1    = mode ? outNext : inNext;
    nxt2    = mode ? inNext  : outNext;
    cfgHit1 = cfgWrEn && !cfgSel;
    cfgHit2 = cfgWrEn &&  cfgSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addr1 <= '0;
      addr2 <= '0;
    end else begin
      addr1 <= cfgHit1 ? cfgData : nxt1;
      addr2 <= cfgHit2 ? cfgData : nxt2;
    end
  end

  assign ram1Addr = addr1;
  assign ram2Addr = addr2;
  assign ram1WrEn = strb.outStep &&  mode;
  assign ram2WrEn = strb.outStep && !mode;
  assign wrData   = outWord;

  a_r9_cfg_ram1: assert property (@(posedge clk) disable iff (!rstN)
    cfgHit1 |=> ram1Addr == $past(cfgData));
  a_r2_aad_base: assert property (@(posedge clk) disable iff (!rstN)
    (strb.inLoadAad && !mode && !cfgHit1) |=> ram1Addr == ADDR_W'(AAD_BASE));
  a_r6_in_step: assert property (@(posedge clk) disable iff (!rstN)
    (strb.inStep && !mode && !cfgHit1) |=> ram1Addr == $past(ram1Addr) + ADDR_W'(1));
  a_r7_out_step: assert property (@(posedge clk) disable iff (!rstN)
    (ram2WrEn && !cfgHit2) |=> ram2Addr == $past(ram2Addr) + ADDR_W'(1));
endmodule

// File: rtl/aadseq_top.sv
module aadseq_top
  import aadseq_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int DATA_W     = 128,
  parameter int BYTE_W     = 16,
  parameter int WORD_BYTES = 16,
  parameter int AAD_BASE   = 'h40,
  localparam int CNT_W     = BYTE_W - $clog2(WORD_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mode,
  input  logic              start,
  input  logic [BYTE_W-1:0] aadBytes,
  input  logic              rdStrobe,
  input  logic              outValid,
  input  logic [DATA_W-1:0] outWord,
  input  logic              cfgWrEn,
  input  logic              cfgSel,
  input  logic [ADDR_W-1:0] cfgData,
  output logic [ADDR_W-1:0] ram1Addr,
  output logic [ADDR_W-1:0] ram2Addr,
  output logic              ram1WrEn,
  output logic              ram2WrEn,
  output logic [DATA_W-1:0] wrData,
  output logic [CNT_W-1:0]  aadLeft
);
  seqStrb_t strb;

  aadseq_ctrl #(.BYTE_W(BYTE_W), .WORD_BYTES(WORD_BYTES)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .aadBytes(aadBytes),
    .rdStrobe(rdStrobe), .outValid(outValid), .strb(strb), .aadLeft(aadLeft)
  );

  aadseq_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .AAD_BASE(AAD_BASE)) dpath_i (
    .clk(clk), .rstN(rstN), .mode(mode), .strb(strb), .cfgWrEn(cfgWrEn),
    .cfgSel(cfgSel), .cfgData(cfgData), .outWord(outWord),
    .ram1Addr(ram1Addr), .ram2Addr(ram2Addr), .ram1WrEn(ram1WrEn),
    .ram2WrEn(ram2WrEn), .wrData(wrData)
  );
endmodule

// File: tb/aadseq_tb_top.sv
`timescale 1ns/1ps
module aadseq_tb_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         mode = 1'b0, start = 1'b0, rdStrobe = 1'b0, outValid = 1'b0;
  logic [15:0]  aadBytes = '0;
  logic [127:0] outWord = '0;
  logic         cfgWrEn = 1'b0, cfgSel = 1'b0;
  logic [6:0]   cfgData = '0;
  logic [6:0]   ram1Addr, ram2Addr;
  logic         ram1WrEn, ram2WrEn;
  logic [127:0] wrData;
  logic [12:0]  aadLeft;

  int checks = 0;
  int errors = 0;

  logic [6:0]  m1 = '0, m2 = '0;
  logic [12:0] mc = '0;
  string       prevTag = "R1";

  always #10 clk = ~clk;

  aadseq_top dut_i (
    .clk(clk), .rstN(rstN), .mode(mode), .start(start), .aadBytes(aadBytes),
    .rdStrobe(rdStrobe), .outValid(outValid), .outWord(outWord),
    .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgData(cfgData),
    .ram1Addr(ram1Addr), .ram2Addr(ram2Addr), .ram1WrEn(ram1WrEn),
    .ram2WrEn(ram2WrEn), .wrData(wrData), .aadLeft(aadLeft)
  );

  function automatic logic [12:0] ceilWords(input logic [15:0] b);
    logic [16:0] r;
    r = {1'b0, b} + 17'd15;
    return r[16:4];
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic checkState();
    chk(ram1Addr == m1, prevTag, "ram1Addr", 128'(ram1Addr), 128'(m1));
    chk(ram2Addr == m2, prevTag, "ram2Addr", 128'(ram2Addr), 128'(m2));
    chk(aadLeft == mc, prevTag, "aadLeft", 128'(aadLeft), 128'(mc));
  endtask

  task automatic cyc(input bit md, input bit st, input logic [15:0] by, input bit rd,
                     input bit ov, input logic [127:0] w, input bit cw, input bit cs,
                     input logic [6:0] cd);
    logic [6:0]  inR, outR;
    logic [12:0] wc;
    @(negedge clk);
    checkState();
    mode = md; start = st; aadBytes = by; rdStrobe = rd; outValid = ov;
    outWord = w; cfgWrEn = cw; cfgSel = cs; cfgData = cd;
    #1;
    // R7 R8: same-cycle write enables and data
    chk(ram1WrEn == (ov && md), "R8", "ram1WrEn", 128'(ram1WrEn), 128'(ov && md));
    chk(ram2WrEn == (ov && !md), "R8", "ram2WrEn", 128'(ram2WrEn), 128'(ov && !md));
    if (ov) chk(wrData == w, "R7", "wrData", wrData, w);
    if (cw) prevTag = "R9";
    else if (st && rd) prevTag = "R10";
    else if (st) prevTag = (by != 0) ? "R2" : "R3";
    else if (rd) prevTag = (mc == 1) ? "R5" : ((mc == 0) ? "R6" : "R4");
    else if (ov) prevTag = "R7";
    else prevTag = "R8";
    inR  = md ? m2 : m1;
    outR = md ? m1 : m2;
    wc   = ceilWords(by);
    if (st) begin
      inR = (wc != 0) ? 7'h40 : 7'h00;
      mc  = wc;
    end else if (rd) begin
      inR = (mc == 1) ? 7'h00 : inR + 7'd1;
      if (mc != 0) mc = mc - 13'd1;
    end
    if (ov) outR = outR + 7'd1;
    m1 = md ? outR : inR;
    m2 = md ? inR : outR;
    if (cw && !cs) m1 = cd;
    if (cw && cs)  m2 = cd;
  endtask

  task automatic idle(input bit md);
    cyc(md, 0, 16'd0, 0, 0, '0, 0, 0, '0);
  endtask

  function automatic logic [127:0] rw();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    #5;
    // R1 reset state
    chk(ram1Addr == 0, "R1", "ram1Addr", 128'(ram1Addr), 0);
    chk(ram2Addr == 0, "R1", "ram2Addr", 128'(ram2Addr), 0);
    chk(aadLeft == 0, "R1", "aadLeft", 128'(aadLeft), 0);
    chk(!ram1WrEn && !ram2WrEn, "R1", "wrEn", 128'({ram1WrEn, ram2WrEn}), 0);
    @(negedge clk); rstN = 1'b1;

    // forward: 40 bytes = 3 words (R2), walk AAD (R4, R5), payload (R6)
    cyc(0, 1, 16'd40, 0, 0, '0, 0, 0, '0);
    cyc(0, 0, 0, 1, 0, '0, 0, 0, '0);
    cyc(0, 0, 0, 1, 0, '0, 0, 0, '0);
    cyc(0, 0, 0, 1, 0, '0, 0, 0, '0);
    cyc(0, 0, 0, 1, 0, '0, 0, 0, '0);
    cyc(0, 0, 0, 1, 1, rw(), 0, 0, '0);
    cyc(0, 0, 0, 0, 1, rw(), 0, 0, '0);
    // R7 wrap of output address
    cyc(0, 0, 0, 0, 0, '0, 1, 1, 7'd127);
    cyc(0, 0, 0, 0, 1, rw(), 0, 0, '0);
    // R2 / R3 rounding edges: 0, 1, 16, 17, 65535 bytes
    cyc(0, 1, 16'd0, 0, 0, '0, 0, 0, '0);
    cyc(0, 1, 16'd1, 0, 0, '0, 0, 0, '0);
    cyc(0, 0, 0, 1, 0, '0, 0, 0, '0);
    cyc(0, 1, 16'd16, 0, 0, '0, 0, 0, '0);
    cyc(0, 1, 16'd17, 0, 0, '0, 0, 0, '0);
    cyc(0, 1, 16'hFFFF, 0, 0, '0, 0, 0, '0);
    // R10 launch with simultaneous read
    cyc(0, 1, 16'd48, 1, 0, '0, 0, 0, '0);
    // reverse mode (R8), register override of a stepping address (R9)
    cyc(1, 0, 0, 0, 0, '0, 1, 0, 7'd0);
    cyc(1, 1, 16'd32, 0, 0, '0, 0, 0, '0);
    cyc(1, 0, 0, 1, 1, rw(), 1, 1, 7'd9);
    cyc(1, 0, 0, 1, 1, rw(), 1, 0, 7'd77);
    cyc(1, 0, 0, 1, 1, rw(), 0, 0, '0);
    idle(1);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      automatic bit md = (i / 200) % 2;
      automatic bit st = ($urandom_range(0, 15) == 0);
      automatic logic [15:0] by = ($urandom_range(0, 9) == 0) ? 16'($urandom) :
                                  16'($urandom_range(0, 120));
      automatic bit cw = ($urandom_range(0, 19) == 0);
      cyc(md, st, by, $urandom_range(0, 1) == 1, $urandom_range(0, 2) == 0, rw(),
          cw, $urandom_range(0, 1) == 1, 7'($urandom));
    end
    idle(0);
    @(negedge clk);
    checkState();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule